// File: doc/BRIEF.md
# Post-Conversion Gain, Brightness and Code-Range Limiter

This block sits right after a triple video converter. It takes three samples per clock. Each sample is scaled by a fine contrast gain of 1 + g/256 and then shifted by a brightness offset. The offset is an offset-binary value, so a setting of 512 adds nothing. The result is then clamped to one of three code ranges. The widest range is full scale. The middle range keeps a small margin at each end. The studio range sets separate upper limits for luma and chroma channels, so each channel carries a luma/chroma flag.

Gain, offset, the luma/chroma flag and the effective range are captured together with the sample. Configuration may therefore change on any cycle without mixing settings inside one sample.

Some settings are not allowed: the reserved range code, or full scale while embedded sync codes are on. In those cases the block substitutes the margin range and raises an illegal-configuration flag. Results appear a fixed two clocks after the input. The qualifier is delayed to match, and between valid samples the outputs hold their last value.

Top module: `pix_level_adjust`

## Requirements
- R1: Each channel's sample x is first scaled to floor((x*(256+g) + 128) / 256), where g is the channel's 8-bit gain field. So g=0 is unity, g=128 is 1.5 and g=255 is just under 2.
- R2: The scaled value then has (offset - 512) added as a signed quantity, where offset is the channel's 10-bit field. Any result below the active lower limit returns that limit, and any result above the upper limit returns that limit.
- R3: Range code 2'b00, with embedded sync off, limits every channel to 0..1023.
- R4: Range code 2'b01 limits every channel to 4..1019.
- R5: Range code 2'b10 limits a channel whose chroma flag is 0 (luma) to 64..940, and a channel whose flag is 1 (chroma) to 64..960.
- R6: Range code 2'b11 is treated as code 2'b01, and cfg_illegal is 1.
- R7: Range code 2'b00 with sync_embed_en=1 is treated as code 2'b01, and cfg_illegal is 1. For codes 2'b01 and 2'b10, cfg_illegal is 0. cfg_illegal reflects the configuration present two clocks earlier, whether or not in_valid is high.
- R8: out_valid equals in_valid delayed by exactly two clocks. The output samples belong to the input presented two clocks earlier, processed with the gain, offset, chroma flags, range code and sync enable present in that same cycle.
- R9: While reset is low, out_valid, out_pix and cfg_illegal are all 0.
- R10: When out_valid is 0, out_pix keeps the value of the last valid result, or 0 if there has been none since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| in_valid | input | 1 | Input sample qualifier |
| in_pix | input | 30 | Three samples, channel c at bits [10c+9:10c] |
| gain | input | 24 | Fine gain g per channel, channel c at bits [8c+7:8c] |
| offset | input | 30 | Offset-binary brightness per channel, channel c at bits [10c+9:10c] |
| range_sel | input | 2 | Code-range select: 00 full, 01 margin, 10 studio, 11 reserved |
| chan_is_chroma | input | 3 | Per-channel flag, 1 marks a chroma channel |
| sync_embed_en | input | 1 | Embedded sync codes are enabled downstream |
| out_valid | output | 1 | Output sample qualifier |
| out_pix | output | 30 | Limited samples, same packing as in_pix |
| cfg_illegal | output | 1 | Disallowed range configuration was substituted |

## Verification
The bench builds the block with its default widths: 10-bit samples, 8-bit gains and three channels. These small widths let it sweep every input code on every channel. The sweep covers each range code with sync off and on, and five gain/offset pairings per channel that include unity, 1.5x and the largest gain. Offsets at 0, 512 and 1023 push results past both ends of every limit. Per-sample chroma flags and a gapped valid pattern reach the luma/chroma split and the hold behaviour.

// File: rtl/pxa_pkg.sv
package pxa_pkg;

  typedef enum logic [1:0] {
    RNG_FULL = 2'b00,
    RNG_EXT  = 2'b01,
    RNG_STD  = 2'b10,
    RNG_RSVD = 2'b11
  } pxa_range_e;

  // Scale a limit defined at 10-bit resolution to a wider sample (DW >= 10).
  function automatic int pxa_scale(input int code10, input int dw);
    return code10 << (dw - 10);
  endfunction

endpackage

// File: rtl/pxa_range_ctrl.sv
module pxa_range_ctrl (
  input  logic [1:0]             range_sel,
  input  logic                   sync_en,
  output pxa_pkg::pxa_range_e    eff_range,
  output logic                   cfg_bad
);
  import pxa_pkg::*;

  pxa_range_e req_range;

  always_comb begin
    req_range = pxa_range_e'(range_sel);
    cfg_bad   = (req_range == RNG_RSVD) || ((req_range == RNG_FULL) && sync_en);
    eff_range = cfg_bad ? RNG_EXT : req_range;
  end

endmodule

// File: rtl/pxa_gain_stage.sv
module pxa_gain_stage #(
  parameter int DW = 10,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] x,
  input  logic [GW-1:0] g,
  input  logic [DW-1:0] off,
  input  logic          is_chroma,
  output logic [DW:0]   prod_q,
  output logic [DW-1:0] off_q,
  output logic          chroma_q
);
  localparam int PW   = DW + GW + 1;
  localparam int HALF = 1 << (GW - 1);

  logic [PW-1:0] full;
  logic [DW:0]   prod_d;

  always_comb begin
    full   = {{(GW+1){1'b0}}, x} * {{DW{1'b0}}, 1'b1, g};
    full   = full + PW'(HALF);
    prod_d = full[PW-1:GW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q   <= '0;
      off_q    <= '0;
      chroma_q <= 1'b0;
    end else if (en) begin
      prod_q   <= prod_d;
      off_q    <= off;
      chroma_q <= is_chroma;
    end
  end

  AST_GAIN_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (prod_q >= {1'b0, $past(x)})); // R1

endmodule

// File: rtl/pxa_limit_stage.sv
module pxa_limit_stage #(
  parameter int DW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [DW:0]         prod,
  input  logic [DW-1:0]       off,
  input  logic                is_chroma,
  input  pxa_pkg::pxa_range_e range_e,
  output logic [DW-1:0]       q
);
  import pxa_pkg::*;

  localparam int SW       = DW + 3;
  localparam int MID      = 1 << (DW - 1);
  localparam int MAXC     = (1 << DW) - 1;
  localparam int EXT_M    = pxa_scale(4, DW);
  localparam int STD_LO   = pxa_scale(64, DW);
  localparam int STD_Y_HI = pxa_scale(940, DW);
  localparam int STD_C_HI = pxa_scale(960, DW);

  logic signed [SW-1:0] sum;
  logic [DW-1:0]        lo, hi, q_d;

  always_comb begin
    case (range_e)
      RNG_FULL: begin
        lo = '0;
        hi = DW'(MAXC);
      end
      RNG_STD: begin
        lo = DW'(STD_LO);
        hi = is_chroma ? DW'(STD_C_HI) : DW'(STD_Y_HI);
      end
      default: begin
        lo = DW'(EXT_M);
        hi = DW'(MAXC - EXT_M);
      end
    endcase
  end

  always_comb begin
    sum = $signed({2'b00, prod}) + $signed({3'b000, off}) - $signed(SW'(MID));
    if (sum < $signed({3'b000, lo}))      q_d = lo;
    else if (sum > $signed({3'b000, hi})) q_d = hi;
    else                                  q_d = sum[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_d;
  end

  AST_OUT_WITHIN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((q >= $past(lo)) && (q <= $past(hi)))); // R3

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R10

endmodule

// File: rtl/pix_level_adjust.sv
module pix_level_adjust #(
  parameter int DW  = 10,
  parameter int GW  = 8,
  parameter int NCH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [NCH*DW-1:0]  in_pix,
  input  logic [NCH*GW-1:0]  gain,
  input  logic [NCH*DW-1:0]  offset,
  input  logic [1:0]         range_sel,
  input  logic [NCH-1:0]     chan_is_chroma,
  input  logic               sync_embed_en,
  output logic               out_valid,
  output logic [NCH*DW-1:0]  out_pix,
  output logic               cfg_illegal
);
  import pxa_pkg::*;

  logic       rst_meta, rst_n_i;
  logic       v1_q, v2_q;
  logic       bad_d, bad1_q, bad2_q;
  pxa_range_e eff_d, range1_q;

  // Reset: asserted asynchronously, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  pxa_range_ctrl u_ctrl (
    .range_sel (range_sel),
    .sync_en   (sync_embed_en),
    .eff_range (eff_d),
    .cfg_bad   (bad_d)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      bad1_q <= 1'b0;
      bad2_q <= 1'b0;
    end else begin
      v1_q   <= in_valid;
      v2_q   <= v1_q;
      bad1_q <= bad_d;
      bad2_q <= bad1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)      range1_q <= RNG_FULL;
    else if (in_valid) range1_q <= eff_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [DW:0]   prod_q;
    logic [DW-1:0] off_q;
    logic          chroma_q;

    pxa_gain_stage #(.DW(DW), .GW(GW)) u_gain (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .en        (in_valid),
      .x         (in_pix[c*DW +: DW]),
      .g         (gain[c*GW +: GW]),
      .off       (offset[c*DW +: DW]),
      .is_chroma (chan_is_chroma[c]),
      .prod_q    (prod_q),
      .off_q     (off_q),
      .chroma_q  (chroma_q)
    );

    pxa_limit_stage #(.DW(DW)) u_limit (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .en        (v1_q),
      .prod      (prod_q),
      .off       (off_q),
      .is_chroma (chroma_q),
      .range_e   (range1_q),
      .q         (out_pix[c*DW +: DW])
    );
  end

  assign out_valid   = v2_q;
  assign cfg_illegal = bad2_q;

  AST_VALID_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n_i)
    in_valid |-> ##2 out_valid); // R8

  AST_IDLE_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n_i)
    !in_valid |-> ##2 !out_valid); // R8

  AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n_i)
    (range_sel == 2'b11) |-> ##2 cfg_illegal); // R6

  AST_FULL_SYNC_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((range_sel == 2'b00) && sync_embed_en) |-> ##2 cfg_illegal); // R7

  AST_LEGAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((range_sel == 2'b01) || (range_sel == 2'b10)) |-> ##2 !cfg_illegal); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_i |-> (!out_valid && !cfg_illegal)); // R9

endmodule

// File: tb/pix_level_adjust_bench.sv
`timescale 1ns/1ps
module pix_level_adjust_bench;
  localparam int DW  = 10;
  localparam int GW  = 8;
  localparam int NCH = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [NCH*DW-1:0] in_pix;
  logic [NCH*GW-1:0] gain;
  logic [NCH*DW-1:0] offset;
  logic [1:0]        range_sel;
  logic [NCH-1:0]    chan_is_chroma;
  logic              sync_embed_en;
  logic              out_valid;
  logic [NCH*DW-1:0] out_pix;
  logic              cfg_illegal;

  always #2.5 clk = ~clk;

  pix_level_adjust #(.DW(DW), .GW(GW), .NCH(NCH)) u_pix_level_adjust (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_pix (in_pix),
    .gain (gain), .offset (offset), .range_sel (range_sel),
    .chan_is_chroma (chan_is_chroma), .sync_embed_en (sync_embed_en),
    .out_valid (out_valid), .out_pix (out_pix), .cfg_illegal (cfg_illegal)
  );

  int checks = 0;
  int errors = 0;
  int k = 0;
  bit hv [4];
  bit hb [4];
  int he [4][NCH];
  string ht [4];
  int last_exp [NCH];
  int gtab [5] = '{0, 128, 255, 1, 64};
  int otab [5] = '{512, 0, 1023, 384, 704};

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (step %0d)", tag, act, exp, k);
    end
  endtask

  function automatic int ref_pix(int x, int g, int o, int rs, bit se, bit chroma);
    int p, s, er, lo, hi;
    p  = (x * (256 + g) + 128) >> 8;
    s  = p + o - 512;
    er = (rs == 3 || (rs == 0 && se)) ? 1 : rs;
    case (er)
      0:       begin lo = 0;  hi = 1023; end
      2:       begin lo = 64; hi = chroma ? 960 : 940; end
      default: begin lo = 4;  hi = 1019; end
    endcase
    if (s < lo) return lo;
    if (s > hi) return hi;
    return s;
  endfunction

  task automatic step(input bit v, input int x, input int gi, input int rs, input bit se);
    int idx, cur, xc, gc, oc;
    bit ch;
    @(negedge clk);
    idx = (k + 2) & 3;
    chk("R8 out_valid", out_valid, hv[idx]);
    chk((rs == 3) ? "R6 cfg_illegal" : "R7 cfg_illegal", cfg_illegal, hb[idx]);
    for (int c = 0; c < NCH; c++) begin
      if (hv[idx]) begin
        chk($sformatf("R1 R2 %s ch%0d", ht[idx], c), out_pix[c*DW +: DW], he[idx][c]);
        last_exp[c] = he[idx][c];
      end else begin
        chk($sformatf("R10 hold ch%0d", c), out_pix[c*DW +: DW], last_exp[c]);
      end
    end
    cur = k & 3;
    in_valid      = v;
    range_sel     = rs[1:0];
    sync_embed_en = se;
    for (int c = 0; c < NCH; c++) begin
      xc = (c == 0) ? x : (c == 1) ? (1023 - x) : ((x * 37 + 11) % 1024);
      gc = gtab[(gi + c) % 5];
      oc = otab[(gi + 2 * c) % 5];
      ch = (x >> c) & 1;
      in_pix[c*DW +: DW]   = xc[DW-1:0];
      gain[c*GW +: GW]     = gc[GW-1:0];
      offset[c*DW +: DW]   = oc[DW-1:0];
      chan_is_chroma[c]    = ch;
      he[cur][c] = ref_pix(xc, gc, oc, rs, se, ch);
    end
    hv[cur] = v;
    hb[cur] = (rs == 3) || (rs == 0 && se);
    ht[cur] = (rs == 3) ? "R6" : (rs == 0 && se) ? "R7" :
              (rs == 0) ? "R3" : (rs == 1) ? "R4" : "R5";
    k++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at step %0d", k);
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; gain = '0; offset = '0;
    range_sel = 2'b00; chan_is_chroma = '0; sync_embed_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      hv[i] = 1'b0; hb[i] = 1'b0; ht[i] = "R9";
      for (int c = 0; c < NCH; c++) he[i][c] = 0;
    end
    for (int c = 0; c < NCH; c++) last_exp[c] = 0;
    repeat (3) @(negedge clk);
    chk("R9 out_valid in reset", out_valid, 0);
    chk("R9 out_pix in reset", int'(out_pix != '0), 0);
    chk("R9 cfg_illegal in reset", cfg_illegal, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int rs = 0; rs < 4; rs++)
      for (int se = 0; se < 2; se++)
        for (int gi = 0; gi < 5; gi++)
          for (int x = 0; x < 1024; x++)
            step((x % 7) != 3, x, gi, rs, se[0]);
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 1, 1'b0);
    summary();
  end

endmodule